// File: doc/BRIEF.md
# Slice Storage Element Group

This block holds the storage of one logic slice: four main cells and four auxiliary cells. All eight share one clock, one clock enable and one set/reset input. Slice-wide configuration bits choose between edge-triggered flip-flops and level-sensitive latches, synchronous or asynchronous set/reset, and clock polarity. They also decide whether the enable and set/reset pins are honoured. Per-cell bits choose the level that set/reset forces and the level that global init loads.

Each auxiliary cell takes its data from a two-way selector. One leg is the LUT secondary output and the other is a bypass input. In latch mode only the main cells act, as latches. The auxiliary cells freeze. Configuration is static and arrives on input ports. It may change only while global init is held high.

Top module: `slice_store_group`

## Requirements
- R1: While `ginit` is high, every cell loads its init level asynchronously, even if `sr` is also high. In flip-flop mode (`cfg_latch`=0) an init bit of 0 loads 1 and 1 loads 0. In latch mode an init bit of 0 loads 0 and 1 loads 1.
- R2: Each cell has its own reset-value bit. When the bit is 1, an active set/reset drives the cell to 0. When the bit is 0, an active set/reset drives the cell to 1.
- R3: In flip-flop mode with `cfg_sync`=1, set/reset takes effect only at the active clock edge. With `cfg_sync`=0 it takes effect at once, without waiting for an edge.
- R4: Clock polarity depends on the mode. In flip-flop mode, `cfg_clk_inv`=0 captures on the rising edge and 1 captures on the falling edge. In latch mode, `cfg_clk_inv`=1 makes the latch transparent while `clk` is high, and 0 makes it transparent while `clk` is low.
- R5: In latch mode the main cells follow `d_main` while the gate is open and the enable is active. They hold when either one is inactive.
- R6: In latch mode the auxiliary cells keep their value. They ignore data, enable and set/reset, and only global init loads them.
- R7: When `cfg_ce_used`=0 the enable is treated as 1 whatever `ce` is.
- R8: When `cfg_sr_used`=0 the `sr` input has no effect.
- R9: For each auxiliary cell, a select bit of 0 feeds the LUT secondary output and a select bit of 1 feeds the bypass input.
- R10: In flip-flop mode each cell captures its data at the active edge when enabled and holds its value otherwise.
- R11: In latch mode set/reset always acts at once, whatever `cfg_sync` is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slice clock, or latch gate in latch mode |
| ginit | input | 1 | Global init, active high, asynchronous |
| ce | input | 1 | Shared clock enable, or gate enable in latch mode |
| sr | input | 1 | Shared set/reset, active high |
| cfg_latch | input | 1 | 1: main cells are latches and auxiliary cells freeze |
| cfg_clk_inv | input | 1 | Clock polarity bit, with mode-dependent sense |
| cfg_sync | input | 1 | 1: synchronous set/reset in flip-flop mode |
| cfg_ce_used | input | 1 | 0: enable forced active |
| cfg_sr_used | input | 1 | 0: set/reset ignored |
| cfg_init_main | input | NUM_MAIN | Init bits of the main cells |
| cfg_init_aux | input | NUM_AUX | Init bits of the auxiliary cells |
| cfg_rstval_main | input | NUM_MAIN | Reset-value bits of the main cells |
| cfg_rstval_aux | input | NUM_AUX | Reset-value bits of the auxiliary cells |
| cfg_aux_sel | input | NUM_AUX | Auxiliary data select per cell (0 LUT, 1 bypass) |
| d_main | input | NUM_MAIN | Data of the main cells |
| lut_sec | input | NUM_AUX | LUT secondary outputs |
| byp | input | NUM_AUX | Bypass inputs |
| q_main | output | NUM_MAIN | Main cell outputs |
| q_aux | output | NUM_AUX | Auxiliary cell outputs |

## Verification
The bench sweeps all eight combinations of latch mode, clock invert and sync mode, plus entries with the enable or set/reset pin unused. For each one it raises set/reset half a nanosecond after the active edge and samples before the next edge. A design with the sync sense reversed, or with latches that wait for an edge, shows the old value there instead of the forced level. Init levels are compared per mode, so init polarity that ignores the mode gives inverted bits. A separate phase-by-phase check of data capture exposes clock-invert senses that fail to flip between the two modes. Auxiliary cells are watched through set/reset pulses in latch mode, so a design that lets them move is caught.

// File: rtl/slice_store_pkg.sv
`timescale 1ns/100ps
package slice_store_pkg;
  // Clock inversion: sense of the bit flips between flip-flop and latch mode.
  function automatic logic clock_flip(input logic latch_mode, input logic inv_bit);
    return inv_bit ^ latch_mode;
  endfunction

  // Level loaded by global init.
  function automatic logic init_level(input logic latch_mode, input logic init_bit);
    return latch_mode ? init_bit : ~init_bit;
  endfunction

  // Level forced by an active set/reset.
  function automatic logic forced_level(input logic rst_bit);
    return ~rst_bit;
  endfunction
endpackage

// File: rtl/slice_store_ctrl.sv
`timescale 1ns/100ps
module slice_store_ctrl
  import slice_store_pkg::*;
(
  input  logic clk,
  input  logic ce,
  input  logic sr,
  input  logic cfg_latch,
  input  logic cfg_clk_inv,
  input  logic cfg_sync,
  input  logic cfg_ce_used,
  input  logic cfg_sr_used,
  output logic clk_eff,
  output logic ce_eff,
  output logic sr_act,
  output logic async_sr,
  output logic sync_sr
);
  assign clk_eff  = clk ^ clock_flip(cfg_latch, cfg_clk_inv);
  assign ce_eff   = cfg_ce_used ? ce : 1'b1;
  assign sr_act   = cfg_sr_used & sr;
  // Latches have no edge, so their set/reset is always immediate.
  assign async_sr = sr_act & (cfg_latch | ~cfg_sync);
  assign sync_sr  = sr_act & cfg_sync & ~cfg_latch;
endmodule

// File: rtl/slice_aux_dmux.sv
`timescale 1ns/100ps
module slice_aux_dmux #(
  parameter int unsigned WIDTH = 4
) (
  input  logic [WIDTH-1:0] sel,
  input  logic [WIDTH-1:0] lut_sec,
  input  logic [WIDTH-1:0] byp,
  output logic [WIDTH-1:0] d_out
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_leg
    assign d_out[i] = sel[i] ? byp[i] : lut_sec[i];
  end
endmodule

// File: rtl/slice_store_cell.sv
`timescale 1ns/100ps
module slice_store_cell
  import slice_store_pkg::*;
#(
  parameter bit IS_AUX = 1'b0
) (
  input  logic clk_eff,
  input  logic ginit,
  input  logic ce_eff,
  input  logic async_sr,
  input  logic sync_sr,
  input  logic latch_mode,
  input  logic init_bit,
  input  logic rst_bit,
  input  logic d,
  output logic q
);
  logic init_lvl, force_lvl, hold, load_async, ff_q;

  assign init_lvl  = init_level(latch_mode, init_bit);
  assign force_lvl = forced_level(rst_bit);

  if (IS_AUX) begin : g_hold
    assign hold = latch_mode;
  end else begin : g_run
    assign hold = 1'b0;
  end

  assign load_async = ginit | (async_sr & ~hold);

  always_ff @(posedge clk_eff or posedge load_async) begin
    if (ginit)                            ff_q <= init_lvl;
    else if (~hold & (async_sr | sync_sr)) ff_q <= force_lvl;
    else if (~hold & ce_eff)              ff_q <= d;
  end

  if (IS_AUX) begin : g_aux
    assign q = ff_q;
  end else begin : g_main
    logic lat_q;
    always_latch begin
      if (ginit)                 lat_q = init_lvl;
      else if (async_sr)         lat_q = force_lvl;
      else if (clk_eff && ce_eff) lat_q = d;
    end
    assign q = latch_mode ? lat_q : ff_q;
  end
endmodule

// File: rtl/slice_store_group.sv
`timescale 1ns/100ps
module slice_store_group #(
  parameter int unsigned NUM_MAIN = 4,
  parameter int unsigned NUM_AUX  = 4
) (
  input  logic                clk,
  input  logic                ginit,
  input  logic                ce,
  input  logic                sr,
  input  logic                cfg_latch,
  input  logic                cfg_clk_inv,
  input  logic                cfg_sync,
  input  logic                cfg_ce_used,
  input  logic                cfg_sr_used,
  input  logic [NUM_MAIN-1:0] cfg_init_main,
  input  logic [NUM_AUX-1:0]  cfg_init_aux,
  input  logic [NUM_MAIN-1:0] cfg_rstval_main,
  input  logic [NUM_AUX-1:0]  cfg_rstval_aux,
  input  logic [NUM_AUX-1:0]  cfg_aux_sel,
  input  logic [NUM_MAIN-1:0] d_main,
  input  logic [NUM_AUX-1:0]  lut_sec,
  input  logic [NUM_AUX-1:0]  byp,
  output logic [NUM_MAIN-1:0] q_main,
  output logic [NUM_AUX-1:0]  q_aux
);
  // Internal events, named for the assertions below.
  logic clk_eff, ce_eff, sr_act, async_sr, sync_sr;
  logic [NUM_AUX-1:0] d_aux;

  slice_store_ctrl u_ctrl (
    .clk(clk), .ce(ce), .sr(sr),
    .cfg_latch(cfg_latch), .cfg_clk_inv(cfg_clk_inv), .cfg_sync(cfg_sync),
    .cfg_ce_used(cfg_ce_used), .cfg_sr_used(cfg_sr_used),
    .clk_eff(clk_eff), .ce_eff(ce_eff), .sr_act(sr_act),
    .async_sr(async_sr), .sync_sr(sync_sr)
  );

  slice_aux_dmux #(.WIDTH(NUM_AUX)) u_dmux (
    .sel(cfg_aux_sel), .lut_sec(lut_sec), .byp(byp), .d_out(d_aux)
  );

  for (genvar i = 0; i < NUM_MAIN; i++) begin : g_main
    slice_store_cell #(.IS_AUX(1'b0)) u_cell (
      .clk_eff(clk_eff), .ginit(ginit), .ce_eff(ce_eff),
      .async_sr(async_sr), .sync_sr(sync_sr), .latch_mode(cfg_latch),
      .init_bit(cfg_init_main[i]), .rst_bit(cfg_rstval_main[i]),
      .d(d_main[i]), .q(q_main[i])
    );
  end

  for (genvar i = 0; i < NUM_AUX; i++) begin : g_aux
    slice_store_cell #(.IS_AUX(1'b1)) u_cell (
      .clk_eff(clk_eff), .ginit(ginit), .ce_eff(ce_eff),
      .async_sr(async_sr), .sync_sr(sync_sr), .latch_mode(cfg_latch),
      .init_bit(cfg_init_aux[i]), .rst_bit(cfg_rstval_aux[i]),
      .d(d_aux[i]), .q(q_aux[i])
    );
  end

  // R3 / R11: immediate set/reset is visible without waiting for an edge.
  assert_async_sr_R3: assert property (@(negedge clk) disable iff (ginit)
    async_sr |-> (q_main == ~cfg_rstval_main));

  // R3: synchronous set/reset lands at the next rising edge (non-inverted FF).
  assert_sync_sr_R3: assert property (@(posedge clk) disable iff (ginit)
    (sync_sr && !cfg_clk_inv) |=> (q_main == ~cfg_rstval_main));

  // R6: auxiliary cells frozen in latch mode.
  assert_aux_hold_R6: assert property (@(posedge clk) disable iff (ginit)
    cfg_latch |=> $stable(q_aux));

  // R7: with the enable unused, each rising edge captures the data.
  assert_ce_forced_R7: assert property (@(posedge clk) disable iff (ginit)
    (!cfg_latch && !cfg_clk_inv && !cfg_ce_used && !sr_act)
      |=> (sr_act || q_main == $past(d_main)));
endmodule

// File: tb/sim_slice_store_group.sv
`timescale 1ns/100ps
module sim_slice_store_group;
  logic clk = 1'b0;
  logic ginit = 1'b1, ce = 1'b1, sr = 1'b0;
  logic cfg_latch = 0, cfg_clk_inv = 0, cfg_sync = 0, cfg_ce_used = 1, cfg_sr_used = 1;
  logic [3:0] cfg_init_main = 4'h0, cfg_init_aux = 4'h0;
  logic [3:0] cfg_rstval_main = 4'h0, cfg_rstval_aux = 4'h0, cfg_aux_sel = 4'h0;
  logic [3:0] d_main = 4'h0, lut_sec = 4'h0, byp = 4'h0;
  logic [3:0] q_main, q_aux;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  slice_store_group u0 (
    .clk(clk), .ginit(ginit), .ce(ce), .sr(sr),
    .cfg_latch(cfg_latch), .cfg_clk_inv(cfg_clk_inv), .cfg_sync(cfg_sync),
    .cfg_ce_used(cfg_ce_used), .cfg_sr_used(cfg_sr_used),
    .cfg_init_main(cfg_init_main), .cfg_init_aux(cfg_init_aux),
    .cfg_rstval_main(cfg_rstval_main), .cfg_rstval_aux(cfg_rstval_aux),
    .cfg_aux_sel(cfg_aux_sel), .d_main(d_main), .lut_sec(lut_sec), .byp(byp),
    .q_main(q_main), .q_aux(q_aux)
  );

  // {latch, clk_inv, sync, ce_used, sr_used, init_m, init_a, rst_m, rst_a, sel}
  localparam logic [24:0] TBL [11] = '{
    {5'b00011, 4'h3, 4'h5, 4'h6, 4'h9, 4'hA},
    {5'b00111, 4'hC, 4'h1, 4'h9, 4'h6, 4'h5},
    {5'b01011, 4'h5, 4'hA, 4'h3, 4'hC, 4'hF},
    {5'b01111, 4'h9, 4'h6, 4'hA, 4'h5, 4'h0},
    {5'b10011, 4'h3, 4'h5, 4'h6, 4'h9, 4'hA},
    {5'b10111, 4'hA, 4'hC, 4'h5, 4'h3, 4'h3},
    {5'b11011, 4'h6, 4'h9, 4'hC, 4'hA, 4'hC},
    {5'b11111, 4'hF, 4'h0, 4'h1, 4'hE, 4'h9},
    {5'b00100, 4'h1, 4'h2, 4'h4, 4'h8, 4'h6},
    {5'b11000, 4'h8, 4'h4, 4'h2, 4'h1, 4'h9},
    {5'b01010, 4'h7, 4'hB, 4'hD, 4'hE, 4'h4}
  };

  // Expected init level: flip-flops load the complement, latches the bit.
  function automatic logic [3:0] exp_init(input logic lat, input logic [3:0] b);
    return lat ? b : ~b;
  endfunction

  // Selected auxiliary source: select bit 1 picks bypass.
  function automatic logic [3:0] pick(input logic [3:0] s, input logic [3:0] l,
                                      input logic [3:0] b);
    logic [3:0] r;
    for (int k = 0; k < 4; k++) r[k] = s[k] ? b[k] : l[k];
    return r;
  endfunction

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wait_active(input logic inv);
    if (inv) @(negedge clk); else @(posedge clk);
  endtask

  task automatic run_entry(input logic [24:0] e);
    logic lat, inv, syn, ceu, sru;
    logic [3:0] im, ia, rm, ra, sl, pm, pa, aux_init;
    {lat, inv, syn, ceu, sru, im, ia, rm, ra, sl} = e;
    aux_init = exp_init(lat, ia);
    ginit = 1'b1; sr = 1'b0; ce = 1'b1;
    cfg_latch = lat; cfg_clk_inv = inv; cfg_sync = syn;
    cfg_ce_used = ceu; cfg_sr_used = sru;
    cfg_init_main = im; cfg_init_aux = ia; cfg_rstval_main = rm;
    cfg_rstval_aux = ra; cfg_aux_sel = sl;
    d_main = 4'hA; lut_sec = 4'h3; byp = 4'h9;
    #8.3;
    chk("R1 init main", q_main, exp_init(lat, im));
    chk("R1 init aux", q_aux, aux_init);
    ginit = 1'b0;
    #9;
    chk("R10/R5 capture main", q_main, 4'hA);
    chk("R9/R6 capture aux", q_aux, lat ? aux_init : pick(sl, 4'h3, 4'h9));
    // Enable low (or unused), new data.
    ce = 1'b0;
    #0.2;
    d_main = 4'h5; lut_sec = 4'hC; byp = 4'h6;
    #9;
    pm = ceu ? 4'hA : 4'h5;
    pa = lat ? aux_init : (ceu ? pick(sl, 4'h3, 4'h9) : pick(sl, 4'hC, 4'h6));
    chk("R7 enable main", q_main, pm);
    chk("R7/R6 enable aux", q_aux, pa);
    // Set/reset raised just after the active edge.
    wait_active(inv);
    #0.5 sr = 1'b1;
    #0.5;
    chk("R3/R11/R8/R2 immediate main", q_main, (sru && (lat || !syn)) ? ~rm : pm);
    chk("R3/R8/R6 immediate aux", q_aux,
        lat ? aux_init : ((sru && !syn) ? ~ra : pa));
    wait_active(inv);
    #1;
    chk("R3/R8/R2 after edge main", q_main, sru ? ~rm : pm);
    chk("R3/R6 after edge aux", q_aux, lat ? aux_init : (sru ? ~ra : pa));
    sr = 1'b0; ce = 1'b1;
    d_main = 4'hC; lut_sec = 4'h5; byp = 4'hA;
    #9;
    chk("R10/R5 recapture main", q_main, 4'hC);
    chk("R9/R6 recapture aux", q_aux, lat ? aux_init : pick(sl, 4'h5, 4'hA));
  endtask

  // Phase test for clock polarity in both modes.
  task automatic polarity(input logic lat, input logic inv);
    ginit = 1'b1; sr = 1'b0; ce = 1'b1;
    cfg_latch = lat; cfg_clk_inv = inv; cfg_sync = 1'b0;
    cfg_ce_used = 1'b1; cfg_sr_used = 1'b1;
    d_main = 4'h0;
    #8.3 ginit = 1'b0;
    #8;
    @(posedge clk);
    #0.5 d_main = 4'hF;
    #0.5;
    if (lat) chk("R4 latch gate in high phase", q_main, inv ? 4'hF : 4'h0);
    else     chk("R4 flop before falling edge", q_main, 4'h0);
    #1.5;
    if (lat) chk("R4 latch gate in low phase", q_main, 4'hF);
    else     chk("R4 flop after falling edge", q_main, inv ? 4'hF : 4'h0);
    #2;
    chk("R4 after full cycle", q_main, 4'hF);
  endtask

  initial begin
    #0.3;
    chk("R1 reset state main", q_main, 4'hF);
    chk("R1 reset state aux", q_aux, 4'hF);
    for (int i = 0; i < 11; i++) run_entry(TBL[i]);
    for (int m = 0; m < 2; m++)
      for (int v = 0; v < 2; v++) polarity(m[0], v[0]);
    // R1: global init wins over an active set/reset.
    ginit = 1'b1; cfg_latch = 1'b0; cfg_sr_used = 1'b1; cfg_sync = 1'b0;
    cfg_init_main = 4'h6; cfg_init_aux = 4'h3;
    cfg_rstval_main = 4'h6; cfg_rstval_aux = 4'h3;
    sr = 1'b1;
    #8.3;
    chk("R1 init over sr main", q_main, 4'h9);
    chk("R1 init over sr aux", q_aux, 4'hC);
    ginit = 1'b0;
    #0.5;
    chk("R2 async force after init", q_main, 4'h9);
    sr = 1'b0;
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule